// File: doc/BRIEF.md
# Flash Write Suspend Controller

This block sits in the command path of a flash device and lets a running byte program operation pause, so that the host can read other array locations, and then continue. Command bytes arrive on bus write cycles. The block talks to an external program sequencer through a level suspend request and four sequencer flags: busy, done, pause acknowledge and programming-voltage valid. It keeps the ready, write-suspended and voltage-error status bits. It also chooses whether a host read returns array data or the status register.

A suspend does not take effect at once. The block raises its request and holds it. The sequencer stops at a checkpoint of its own choosing and then acknowledges. While paused, only three commands are acted upon: select array reads, select status reads and resume. A resume drops the request, and the sequencer continues the byte from where it stopped.

Top module: `fws_ctrl`

## Requirements
- R1: After reset the read path returns array data, the suspend request is low, and the status register reads 0x80 (bit 7 ready = 1, all other bits 0).
- R2: Command 0xB0 written while a program runs raises the suspend request on the next cycle. The request stays high until the sequencer acknowledges, and status bit 7 reads 0 during that wait.
- R3: After 0xB0 is accepted, reads return the status register until 0xFF is written.
- R4: One cycle after the sequencer acknowledges the pause, status bits 7 and 2 both read 1 (status 0x84) and the suspend request stays high.
- R5: While paused, 0xFF switches reads to array data at any address and 0x70 switches them back to the status register.
- R6: While paused, any command byte other than 0xFF, 0x70 and 0xD0 (including 0xB0) is ignored: the status value and the read selection stay as they were.
- R7: 0xD0 written while paused, with the voltage flag high and no voltage error recorded, drops the suspend request on the next cycle. Status bits 7 and 2 clear at the same time, and reads return the status register.
- R8: 0xB0 written while no program runs has no effect: the request stays low, the read selection is unchanged and the status stays 0x80.
- R9: If the voltage flag is low during the pause, status bit 3 is set (status 0x8C) and stays set until reset. A later 0xD0 is refused: the request stays high and bit 2 stays 1.
- R10: A running program shows status 0x00. When the sequencer reports done, status returns to 0x80. A byte that was paused and resumed is then readable in the array.
- R11: The sequencer acknowledges a suspend request within LAT_MAX cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_we_i | input | 1 | Command write strobe, one cycle per command |
| cmd_data_i | input | DW | Command byte |
| seq_busy_i | input | 1 | Sequencer is running a byte program |
| seq_ack_i | input | 1 | Sequencer is paused at its checkpoint |
| seq_done_i | input | 1 | One-cycle pulse when the byte program finishes |
| vpp_ok_i | input | 1 | Programming voltage valid |
| arr_rdata_i | input | DW | Array data for the current read address |
| susp_req_o | output | 1 | Level request for the sequencer to pause; low means continue |
| rd_data_o | output | DW | Host read data: status register or array data |

## Verification
The assertions check on every cycle the parts of the handshake and filter that look at a single step. They cover the request hold while no acknowledge has come, the ready and suspend flags after an acknowledge, the stability of status and read selection under ignored bytes, the voltage error capture, the resume edge and the acknowledge latency bound. Only the bench scenarios can show the whole sequence: an array read of another location during the pause returns that location's data, and the paused byte lands in the array with the right value after resume. The same holds for a refused resume leaving the operation frozen, and for a suspend outside a program leaving everything untouched.

// File: rtl/fws_pkg.sv
package fws_pkg;
  localparam logic [7:0] OP_SUSPEND = 8'hB0;
  localparam logic [7:0] OP_RESUME  = 8'hD0;
  localparam logic [7:0] OP_STATUS  = 8'h70;
  localparam logic [7:0] OP_ARRAY   = 8'hFF;

  localparam int RDY_BIT  = 7;
  localparam int VERR_BIT = 3;
  localparam int WSUS_BIT = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RUN, ST_SREQ, ST_SUSP, ST_RSM
  } fws_state_e;

  typedef enum logic [2:0] {
    CK_NONE, CK_ARRAY, CK_STAT, CK_SUSP, CK_RSM
  } fws_cmd_e;
endpackage

// File: rtl/fws_cmd_dec.sv
module fws_cmd_dec
  import fws_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          we_i,
  input  logic [DW-1:0] byte_i,
  output fws_cmd_e      kind_o
);
  always_comb begin
    kind_o = CK_NONE;
    if (we_i) begin
      if (byte_i == DW'(OP_ARRAY))        kind_o = CK_ARRAY;
      else if (byte_i == DW'(OP_STATUS))  kind_o = CK_STAT;
      else if (byte_i == DW'(OP_SUSPEND)) kind_o = CK_SUSP;
      else if (byte_i == DW'(OP_RESUME))  kind_o = CK_RSM;
    end
  end
endmodule

// File: rtl/fws_fsm.sv
module fws_fsm
  import fws_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  fws_cmd_e   kind_i,
  input  logic       seq_busy_i,
  input  logic       seq_ack_i,
  input  logic       seq_done_i,
  input  logic       vpp_ok_i,
  output fws_state_e st_o,
  output logic       verr_o,
  output logic       sel_stat_o,
  output logic       susp_req_o
);
  fws_state_e st_q, st_d;
  logic       verr_q, verr_d;
  logic       sel_q, sel_d;
  logic       en;

  always_comb begin
    st_d   = st_q;
    verr_d = verr_q;
    sel_d  = sel_q;
    if (kind_i == CK_ARRAY) sel_d = 1'b0;
    if (kind_i == CK_STAT)  sel_d = 1'b1;
    case (st_q)
      ST_IDLE: if (seq_busy_i) st_d = ST_RUN;
      ST_RUN: begin
        if (seq_done_i) st_d = ST_IDLE;
        else if (kind_i == CK_SUSP) begin
          st_d  = ST_SREQ;
          sel_d = 1'b1;
        end
      end
      ST_SREQ: begin
        if (seq_done_i)     st_d = ST_IDLE;
        else if (seq_ack_i) st_d = ST_SUSP;
      end
      ST_SUSP: begin
        if (!vpp_ok_i) verr_d = 1'b1;
        if (kind_i == CK_RSM && vpp_ok_i && !verr_q) begin
          st_d  = ST_RSM;
          sel_d = 1'b1;
        end
      end
      ST_RSM: begin
        if (seq_done_i)      st_d = ST_IDLE;
        else if (!seq_ack_i) st_d = ST_RUN;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign en = (st_d != st_q) || (verr_d != verr_q) || (sel_d != sel_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      verr_q <= 1'b0;
      sel_q  <= 1'b0;
    end else if (en) begin
      st_q   <= st_d;
      verr_q <= verr_d;
      sel_q  <= sel_d;
    end
  end

  assign st_o       = st_q;
  assign verr_o     = verr_q;
  assign sel_stat_o = sel_q;
  assign susp_req_o = (st_q == ST_SREQ) || (st_q == ST_SUSP);

  // R2: request held while the sequencer has not yet paused
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_req_o && !seq_ack_i && !seq_done_i && st_q == ST_SREQ) |=> susp_req_o);

  // R7: accepted resume drops the request and selects status reads
  p_resume_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SUSP && kind_i == CK_RSM && vpp_ok_i && !verr_q)
      |=> (!susp_req_o && sel_stat_o));

  // R9: error is sticky once captured
  p_verr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    verr_q |=> verr_q);
endmodule

// File: rtl/fws_rdmux.sv
module fws_rdmux
  import fws_pkg::*;
#(
  parameter int DW = 8
) (
  input  fws_state_e    st_i,
  input  logic          verr_i,
  input  logic          sel_stat_i,
  input  logic [DW-1:0] arr_i,
  output logic [DW-1:0] stat_o,
  output logic [DW-1:0] rd_o
);
  always_comb begin
    stat_o           = '0;
    stat_o[RDY_BIT]  = (st_i == ST_IDLE) || (st_i == ST_SUSP);
    stat_o[WSUS_BIT] = (st_i == ST_SUSP);
    stat_o[VERR_BIT] = verr_i;
  end

  assign rd_o = sel_stat_i ? stat_o : arr_i;
endmodule

// File: rtl/fws_ctrl.sv
module fws_ctrl
  import fws_pkg::*;
#(
  parameter int DW      = 8,
  parameter int LAT_MAX = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we_i,
  input  logic [DW-1:0] cmd_data_i,
  input  logic          seq_busy_i,
  input  logic          seq_ack_i,
  input  logic          seq_done_i,
  input  logic          vpp_ok_i,
  input  logic [DW-1:0] arr_rdata_i,
  output logic          susp_req_o,
  output logic [DW-1:0] rd_data_o
);
  localparam int LCW = $clog2(LAT_MAX + 2);

  logic [1:0]    rst_q;
  logic          rst_s;
  fws_cmd_e      kind;
  fws_state_e    st;
  logic          verr;
  logic          sel_stat;
  logic [DW-1:0] stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_s = rst_q[1];

  fws_cmd_dec #(.DW(DW)) i_dec (
    .we_i   (cmd_we_i),
    .byte_i (cmd_data_i),
    .kind_o (kind)
  );

  fws_fsm i_fsm (
    .clk        (clk),
    .rst_n      (rst_s),
    .kind_i     (kind),
    .seq_busy_i (seq_busy_i),
    .seq_ack_i  (seq_ack_i),
    .seq_done_i (seq_done_i),
    .vpp_ok_i   (vpp_ok_i),
    .st_o       (st),
    .verr_o     (verr),
    .sel_stat_o (sel_stat),
    .susp_req_o (susp_req_o)
  );

  fws_rdmux #(.DW(DW)) i_mux (
    .st_i       (st),
    .verr_i     (verr),
    .sel_stat_i (sel_stat),
    .arr_i      (arr_rdata_i),
    .stat_o     (stat),
    .rd_o       (rd_data_o)
  );

  // latency watch for R11
  logic [LCW-1:0] lat_q;
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)                     lat_q <= '0;
    else if (st == ST_SREQ)         lat_q <= lat_q + 1'b1;
    else if (lat_q != '0)           lat_q <= '0;
  end

  p_ack_latency_r11: assert property (@(posedge clk) disable iff (!rst_s)
    lat_q <= LCW'(LAT_MAX));

  // R4: acknowledge turns into ready plus suspended
  p_pause_flags_r4: assert property (@(posedge clk) disable iff (!rst_s)
    (susp_req_o && seq_ack_i && !seq_done_i && !stat[WSUS_BIT])
      |=> (stat[RDY_BIT] && stat[WSUS_BIT] && susp_req_o));

  // R6: filtered bytes change nothing while paused
  p_filter_r6: assert property (@(posedge clk) disable iff (!rst_s)
    (stat[WSUS_BIT] && vpp_ok_i && cmd_we_i && cmd_data_i != DW'(OP_ARRAY) &&
     cmd_data_i != DW'(OP_STATUS) && cmd_data_i != DW'(OP_RESUME))
      |=> ($stable(stat) && $stable(sel_stat)));

  // R8: suspend outside a program is without effect
  p_idle_susp_r8: assert property (@(posedge clk) disable iff (!rst_s)
    (st == ST_IDLE && !seq_busy_i && cmd_we_i && cmd_data_i == DW'(OP_SUSPEND))
      |=> (!susp_req_o && $stable(sel_stat) && $stable(stat)));

  // R9: voltage loss during pause is recorded and keeps the pause
  p_verr_r9: assert property (@(posedge clk) disable iff (!rst_s)
    (stat[WSUS_BIT] && !vpp_ok_i) |=> (stat[VERR_BIT] && stat[WSUS_BIT]));
endmodule

// File: tb/test_fws_ctrl.sv
module test_fws_ctrl;
  localparam int SEQ_LAT  = 5;
  localparam int PROG_CYC = 40;
  localparam logic [7:0] PVAL = 8'hC3;
  localparam int TGT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_we = 1'b0;
  logic [7:0] cmd_data = 8'h00;
  logic vpp_ok = 1'b1;
  logic [3:0] addr = 4'd0;
  logic start = 1'b0;
  logic busy, ack, done;
  logic susp_req;
  logic [7:0] rd_data;
  logic [7:0] mem [16];
  logic [7:0] arr;
  int left, lcnt;
  int total = 0, fails = 0;

  always #4 clk = ~clk;

  assign arr = mem[addr];

  fws_ctrl i_fws_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_we_i(cmd_we), .cmd_data_i(cmd_data),
    .seq_busy_i(busy), .seq_ack_i(ack), .seq_done_i(done), .vpp_ok_i(vpp_ok),
    .arr_rdata_i(arr), .susp_req_o(susp_req), .rd_data_o(rd_data)
  );

  function automatic logic [7:0] arr_pat(int a);
    return {a[3:0], 4'b0101};
  endfunction

  function automatic logic [7:0] st_val(bit rdy, bit sus, bit ve);
    return {rdy, 3'b000, ve, sus, 2'b00};
  endfunction

  // sequencer model with a fixed pause latency
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; ack <= 1'b0; done <= 1'b0; left <= 0; lcnt <= 0;
      for (int i = 0; i < 16; i++) mem[i] <= arr_pat(i);
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1; left <= PROG_CYC;
      end else if (busy) begin
        if (ack) begin
          if (!susp_req) begin ack <= 1'b0; lcnt <= 0; end
        end else if (susp_req) begin
          if (lcnt == SEQ_LAT - 1) ack <= 1'b1;
          lcnt <= lcnt + 1;
        end else if (left == 1) begin
          busy <= 1'b0; done <= 1'b1; mem[TGT] <= PVAL;
        end else left <= left - 1;
      end
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] b);
    @(negedge clk); cmd_we = 1'b1; cmd_data = b;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; vpp_ok = 1'b1;
    idle(2); rst_n = 1'b1; idle(4);
  endtask

  task automatic wait_ack();
    for (int i = 0; i < 50 && !ack; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic start_prog();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    idle(2);
  endtask

  initial begin
    #(8 * 100000);
    total++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] b;
    void'($urandom(32'h5EED_F1A5));
    do_reset();
    addr = 4'd9;
    idle(1);
    chk("R1 array after reset", rd_data, arr_pat(9));
    chk("R1 req low", {7'b0, susp_req}, 8'd0);
    wr(8'h70);
    chk("R1 status after reset", rd_data, st_val(1, 0, 0));

    // suspend with a program running
    wr(8'hFF);
    start_prog();
    wr(8'h70);
    chk("R10 running status", rd_data, st_val(0, 0, 0));
    wr(8'hFF);
    wr(8'hB0);
    chk("R2 req raised", {7'b0, susp_req}, 8'd1);
    chk("R3 status after suspend", rd_data, st_val(0, 0, 0));
    idle(2);
    chk("R2 still waiting", {7'b0, susp_req}, 8'd1);
    wait_ack();
    chk("R4 paused flags", rd_data, st_val(1, 1, 0));
    chk("R4 req held", {7'b0, susp_req}, 8'd1);

    wr(8'hFF);
    for (int i = 0; i < 6; i++) begin
      addr = 4'($urandom_range(0, 15));
      if (addr == 4'(TGT)) addr = 4'd0;
      idle(1);
      chk("R5 array read in pause", rd_data, arr_pat(int'(addr)));
    end
    for (int i = 0; i < 12; i++) begin
      b = 8'($urandom);
      if (b == 8'hFF || b == 8'h70 || b == 8'hD0) b = 8'hB0;
      wr(b);
      chk("R6 ignored in array mode", rd_data, arr_pat(int'(addr)));
    end
    wr(8'h70);
    chk("R5 status select in pause", rd_data, st_val(1, 1, 0));
    for (int i = 0; i < 12; i++) begin
      b = 8'($urandom);
      if (b == 8'hFF || b == 8'h70 || b == 8'hD0) b = 8'h20;
      wr(b);
      chk("R6 ignored in status mode", rd_data, st_val(1, 1, 0));
      chk("R6 req unchanged", {7'b0, susp_req}, 8'd1);
    end

    wr(8'hFF);
    wr(8'hD0);
    chk("R7 req dropped", {7'b0, susp_req}, 8'd0);
    chk("R7 flags cleared", rd_data, st_val(0, 0, 0));
    idle(PROG_CYC + 6);
    chk("R10 ready after done", rd_data, st_val(1, 0, 0));
    wr(8'hFF);
    addr = 4'(TGT);
    idle(1);
    chk("R10 paused byte written", rd_data, PVAL);

    // suspend with nothing running
    addr = 4'd5;
    wr(8'hB0);
    chk("R8 mode unchanged", rd_data, arr_pat(5));
    chk("R8 no request", {7'b0, susp_req}, 8'd0);
    wr(8'h70);
    chk("R8 status unchanged", rd_data, st_val(1, 0, 0));

    // voltage loss during pause
    do_reset();
    start_prog();
    wr(8'hB0);
    wait_ack();
    @(negedge clk); vpp_ok = 1'b0;
    idle(2);
    chk("R9 error recorded", rd_data, st_val(1, 1, 1));
    @(negedge clk); vpp_ok = 1'b1;
    wr(8'hD0);
    idle(2);
    chk("R9 resume refused req", {7'b0, susp_req}, 8'd1);
    chk("R9 resume refused status", rd_data, st_val(1, 1, 1));

    do_reset();
    addr = 4'd12;
    idle(1);
    chk("R1 array after second reset", rd_data, arr_pat(12));
    chk("R1 req low after second reset", {7'b0, susp_req}, 8'd0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule